// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Slave Address Filtering

This block receives asynchronous serial frames on one line and presents each byte to software through a small register port. A frame is a low start bit, eight data bits with the least significant bit first, an optional ninth bit, and a high stop bit. The line is sampled on a 16x oversampling tick that comes from outside the block. Each bit is settled by a majority vote taken around the middle of the bit.

In the nine-bit modes the receiver can act as a slave on a shared multi-drop line. When multiprocessor filtering is on, a frame only raises the receive flag if its ninth bit is 1 and its byte names this slave. The byte names this slave when it matches the masked slave address, or when it matches the broadcast pattern made from the same two registers. Software turns filtering off once its own address has arrived, so that the data bytes that follow are taken. It turns filtering back on when the message ends.

A stop bit sampled as 0 sets a sticky framing-error flag. Software reads and clears that flag through the same control-register position that otherwise holds the upper mode bit. A select bit in a separate option register picks which of the two that position shows.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, every register reads 0: control (offset 0), data (offset 1), slave address (offset 2), mask (offset 3) and option (offset 4). Control fields: bit 7 = upper mode bit or framing error, bit 6 = lower mode bit, bit 5 = filter enable, bit 4 = receive enable, bit 2 = received ninth bit, bit 0 = receive flag. Option bit 0 is the alias select.
- R2: Each bit lasts 16 ticks and is decided by a majority of the line samples at ticks 7, 8 and 9 of the bit, counted from the tick that saw the start edge as tick 0. Data bits arrive LSB first, and an accepted byte reads at offset 1.
- R3: A low pulse whose majority vote at the middle of the start bit is high is dropped, and no frame is received from it.
- R4: In a nine-bit mode (mode 2 or 3) with filtering off, every frame with a high stop bit sets the flag and loads the byte and the ninth bit, whatever their values.
- R5: In a nine-bit mode with filtering on, a frame is accepted only if its ninth bit is 1 and the byte matches a recognised address. It matches the given address when ((byte XOR address) AND mask) is 0. A rejected frame changes neither the flag nor the data register.
- R6: The broadcast pattern is address OR mask. A byte that has a 1 in every bit position where the pattern is 1 is also recognised.
- R7: A stop bit sampled low sets the framing-error flag and the frame is not accepted. The framing-error flag stays set through later frames.
- R8: With option bit 0 = 1, control bit 7 reads and writes the framing-error flag. With option bit 0 = 0, it reads and writes the upper mode bit. Writing 0 through the alias is the only way to clear the error flag.
- R9: The receive flag stays set until software writes control bit 0 as 0.
- R10: In mode 0, the receiver ignores the line whatever the filter enable holds, and no frame is received.
- R11: In mode 1, frames have no ninth bit (10 bits in all) and filtering has no effect. The received ninth bit takes the stop-bit value.
- R12: With receive enable at 0, frames on the line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial line, idle high, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
A wrong bit counter or phase counter shows at the data register as a shifted or corrupted byte after the very next frame. A wrong filter decision shows as a flag raised or withheld one cycle after the stop-bit vote. The sweep of all 256 byte values under filtering exposes any wrong match term, because each given-address or broadcast bit position changes the flag for some byte. Stale state in the sticky error flag or the receive flag shows on the next control read, which the bench takes after every frame.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned REG_AW = 3;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [REG_AW-1:0] {
        RS_CTRL  = 3'd0,
        RS_DATA  = 3'd1,
        RS_SADDR = 3'd2,
        RS_MASK  = 3'd3,
        RS_OPT   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        MD_SHIFT = 2'b00,
        MD_BYTE  = 2'b01,
        MD_NINE_A = 2'b10,
        MD_NINE_B = 2'b11
    } mode_e;

    // control register bit positions
    localparam int unsigned CB_MODE_HI = 7;
    localparam int unsigned CB_MODE_LO = 6;
    localparam int unsigned CB_FILT    = 5;
    localparam int unsigned CB_RXEN    = 4;
    localparam int unsigned CB_RX9     = 2;
    localparam int unsigned CB_FLAG    = 0;

    typedef struct packed {
        byte_t data;
        logic  ninth;
        logic  stop_ok;
    } frame_t;

    function automatic logic vote3(input logic [1:0] ones, input logic last);
        logic [1:0] total;
        total = ones + {1'b0, last};
        return total >= 2'd2;
    endfunction

    function automatic logic has_ninth(input mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/mp_uart_rx_sync.sv
module mp_uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/mp_uart_rx_frame.sv
module mp_uart_rx_frame
    import mp_uart_rx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   en,
    input  logic   nine,
    input  logic   line,
    output logic   done,
    output frame_t frame
);
    localparam int unsigned PH_W = $clog2(OVS);
    localparam int unsigned MID  = OVS / 2;
    localparam logic [PH_W-1:0] PH_A    = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_B    = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_V    = PH_W'(MID + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam int unsigned BN_W = $clog2(DATA_W + 3);
    localparam logic [BN_W-1:0] BN_LAST_DATA = BN_W'(DATA_W);
    localparam logic [BN_W-1:0] BN_STOP8     = BN_W'(DATA_W + 1);
    localparam logic [BN_W-1:0] BN_STOP9     = BN_W'(DATA_W + 2);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e             st;
    logic [PH_W-1:0] ph;
    logic [BN_W-1:0] bn;
    logic [1:0]      ones;
    byte_t           shreg;
    logic            b9;
    logic            v;
    logic [BN_W-1:0] bn_stop;

    assign v       = vote3(ones, line);
    assign bn_stop = nine ? BN_STOP9 : BN_STOP8;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            ph    <= '0;
            bn    <= '0;
            ones  <= '0;
            shreg <= '0;
            b9    <= 1'b0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st <= ST_IDLE;
            end else if (tick) begin
                unique case (st)
                    ST_IDLE: begin
                        if (!line) begin
                            st <= ST_RUN;
                            ph <= PH_W'(1);
                            bn <= '0;
                        end
                    end
                    ST_RUN: begin
                        ph <= (ph == PH_LAST) ? '0 : ph + PH_W'(1);
                        if (ph == PH_A) begin
                            ones <= {1'b0, line};
                        end else if (ph == PH_B) begin
                            ones <= ones + {1'b0, line};
                        end else if (ph == PH_V) begin
                            bn <= bn + BN_W'(1);
                            if (bn == '0) begin
                                if (v) st <= ST_IDLE;
                            end else if (bn == bn_stop) begin
                                done          <= 1'b1;
                                frame.data    <= shreg;
                                frame.ninth   <= nine ? b9 : v;
                                frame.stop_ok <= v;
                                st            <= ST_IDLE;
                            end else if (bn <= BN_LAST_DATA) begin
                                shreg <= {v, shreg[DATA_W-1:1]};
                            end else begin
                                b9 <= v;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == ST_IDLE) && !done); // R12

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(tick) && $past(en)); // R2
endmodule

// File: rtl/mp_uart_rx_match.sv
module mp_uart_rx_match
    import mp_uart_rx_pkg::*;
(
    input  byte_t rx_byte,
    input  byte_t saddr,
    input  byte_t mask,
    output logic  hit
);
    byte_t bcast;
    logic  given_hit;
    logic  bcast_hit;

    always_comb begin
        bcast     = saddr | mask;
        given_hit = ((rx_byte ^ saddr) & mask) == '0;
        bcast_hit = (rx_byte & bcast) == bcast;
        hit       = given_hit | bcast_hit;
    end
endmodule

// File: rtl/mp_uart_rx_regs.sv
module mp_uart_rx_regs
    import mp_uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  byte_t    wr_data,
    output byte_t    rd_data,
    input  logic     done,
    input  frame_t   frame,
    input  logic     hit,
    output mode_e    mode,
    output logic     rx_en,
    output byte_t    saddr,
    output byte_t    mask
);
    logic  mode_hi, mode_lo, filt, rx9, flag, fe, fe_sel;
    byte_t data_q;
    logic  ctrl_wr, accept, fe_set, filtering;

    assign mode      = mode_e'({mode_hi, mode_lo});
    assign ctrl_wr   = wr_en && (sel == RS_CTRL);
    assign filtering = has_ninth(mode) && filt;
    assign accept    = done && frame.stop_ok && (!filtering || (frame.ninth && hit));
    assign fe_set    = done && !frame.stop_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_hi <= 1'b0;
            mode_lo <= 1'b0;
            filt    <= 1'b0;
            rx_en   <= 1'b0;
            rx9     <= 1'b0;
            flag    <= 1'b0;
            fe      <= 1'b0;
            fe_sel  <= 1'b0;
            data_q  <= '0;
            saddr   <= '0;
            mask    <= '0;
        end else begin
            if (wr_en) begin
                unique case (sel)
                    RS_CTRL: begin
                        if (fe_sel) fe      <= wr_data[CB_MODE_HI];
                        else        mode_hi <= wr_data[CB_MODE_HI];
                        mode_lo <= wr_data[CB_MODE_LO];
                        filt    <= wr_data[CB_FILT];
                        rx_en   <= wr_data[CB_RXEN];
                        rx9     <= wr_data[CB_RX9];
                        flag    <= wr_data[CB_FLAG];
                    end
                    RS_SADDR: saddr  <= wr_data;
                    RS_MASK:  mask   <= wr_data;
                    RS_OPT:   fe_sel <= wr_data[0];
                    default: ;
                endcase
            end
            if (accept) begin
                flag   <= 1'b1;
                rx9    <= frame.ninth;
                data_q <= frame.data;
            end
            if (fe_set) fe <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            RS_CTRL: begin
                rd_data[CB_MODE_HI] = fe_sel ? fe : mode_hi;
                rd_data[CB_MODE_LO] = mode_lo;
                rd_data[CB_FILT]    = filt;
                rd_data[CB_RXEN]    = rx_en;
                rd_data[CB_RX9]     = rx9;
                rd_data[CB_FLAG]    = flag;
            end
            RS_DATA:  rd_data = data_q;
            RS_SADDR: rd_data = saddr;
            RS_MASK:  rd_data = mask;
            RS_OPT:   rd_data[0] = fe_sel;
            default:  rd_data = '0;
        endcase
    end

    AST_FLAG_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag) && !$past(ctrl_wr)) |-> ($past(done) && $past(frame.stop_ok))); // R4

    AST_FILTER_REJECT: assert property (@(posedge clk) disable iff (rst)
        (done && has_ninth(mode) && filt && !(frame.ninth && hit) && !ctrl_wr)
        |=> $stable(flag) && $stable(data_q)); // R5

    AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fe && !(ctrl_wr && fe_sel && !wr_data[CB_MODE_HI])) |=> fe); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag && !ctrl_wr) |=> flag); // R9
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mp_uart_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        baud_tick,
    input  logic        rx_line,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata
);
    logic   line_s;
    logic   done;
    frame_t frame;
    logic   hit;
    mode_e  mode;
    logic   rx_en;
    byte_t  saddr, mask;
    logic   fr_en;

    assign fr_en = rx_en && (mode != MD_SHIFT);

    mp_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(line_s)
    );

    mp_uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .tick (baud_tick),
        .en   (fr_en),
        .nine (has_ninth(mode)),
        .line (line_s),
        .done (done),
        .frame(frame)
    );

    mp_uart_rx_match u_match (
        .rx_byte(frame.data),
        .saddr  (saddr),
        .mask   (mask),
        .hit    (hit)
    );

    mp_uart_rx_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_we),
        .sel    (reg_sel_e'(reg_addr)),
        .wr_data(reg_wdata),
        .rd_data(reg_rdata),
        .done   (done),
        .frame  (frame),
        .hit    (hit),
        .mode   (mode),
        .rx_en  (rx_en),
        .saddr  (saddr),
        .mask   (mask)
    );

    AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SHIFT) |=> !done); // R10
endmodule

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int div = 1;
    int tcnt = 0;
    bit finished = 0;

    mp_uart_rx u_mp_uart_rx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_line(rx_line),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (tcnt >= div - 1) begin
            tcnt = 0;
            baud_tick <= 1'b1;
        end else begin
            tcnt = tcnt + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic send_bit(input bit v);
        rx_line = v;
        repeat (16 * div) @(negedge clk);
    endtask

    task automatic send_frame(input int b, input bit b9, input bit stop, input bit nine);
        @(negedge clk);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        if (nine) send_bit(b9);
        send_bit(stop);
        rx_line = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic bit hit_of(input int b, input int sa, input int mk);
        int bc;
        bc = (sa | mk) & 255;
        return (((b ^ sa) & mk) == 0) || ((b & bc) == bc);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d, c, exp_data;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state of every register
        for (int a = 0; a < 5; a++) begin
            rd(a, d); chk("R1 reset value", d, 0);
        end

        // R4 nine-bit mode 2, filter off: any content is taken
        wr(0, 8'h90);
        send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
        rd(0, c); chk("R4 flag set", c & 1, 1);
        chk("R4 ninth bit 0", (c >> 2) & 1, 0);
        rd(1, d); chk("R2 R4 data A5", d, 8'hA5);
        wr(0, 8'h90);
        send_frame(8'h3C, 1'b1, 1'b1, 1'b1);
        rd(0, c); chk("R4 ninth bit 1", (c >> 2) & 1, 1);
        rd(1, d); chk("R2 data 3C", d, 8'h3C);
        wr(0, 8'h90);
        send_frame(8'h00, 1'b1, 1'b1, 1'b1);
        rd(1, d); chk("R2 data 00", d, 0);
        wr(0, 8'h90);
        send_frame(8'hFF, 1'b0, 1'b1, 1'b1);
        rd(1, d); chk("R2 data FF", d, 8'hFF);
        wr(0, 8'h90);

        // R3 short low glitch is not a start bit
        @(negedge clk);
        rx_line = 1'b0; repeat (4) @(negedge clk); rx_line = 1'b1;
        repeat (300) @(negedge clk);
        rd(0, c); chk("R3 glitch no flag", c & 1, 0);
        send_frame(8'h81, 1'b0, 1'b1, 1'b1);
        rd(1, d); chk("R3 frame after glitch", d, 8'h81);
        wr(0, 8'h90);
        exp_data = 8'h81;

        // R5 R6 full byte sweep, address C0 mask FD, filter on
        wr(2, 8'hC0); wr(3, 8'hFD); wr(0, 8'hB0);
        for (int b = 0; b < 256; b++) begin
            bit h;
            h = hit_of(b, 8'hC0, 8'hFD);
            send_frame(b, 1'b1, 1'b1, 1'b1);
            rd(0, c); chk("R5 R6 sweep flag", c & 1, int'(h));
            if (h) exp_data = b;
            rd(1, d); chk("R5 sweep data", d, exp_data);
            if (h) wr(0, 8'hB0);
        end

        // R5 address byte with ninth bit 0 is ignored
        send_frame(8'hC0, 1'b0, 1'b1, 1'b1);
        rd(0, c); chk("R5 ninth bit 0 rejected", c & 1, 0);

        // R5 R6 second slave: mask FE
        wr(3, 8'hFE);
        for (int k = 0; k < 7; k++) begin
            int b;
            bit h;
            b = (k < 4) ? (8'hC0 + k) : (k == 4 ? 8'hFE : (k == 5 ? 8'hFF : 8'h7F));
            h = hit_of(b, 8'hC0, 8'hFE);
            send_frame(b, 1'b1, 1'b1, 1'b1);
            rd(0, c); chk("R5 R6 mask FE flag", c & 1, int'(h));
            if (h) wr(0, 8'hB0);
        end

        // R11 mode 1 with filter bit set: ten-bit frames, no filtering
        wr(0, 8'h70);
        send_frame(8'h5A, 1'b0, 1'b1, 1'b0);
        rd(0, c); chk("R11 flag", c & 1, 1);
        chk("R11 ninth is stop", (c >> 2) & 1, 1);
        rd(1, d); chk("R11 data", d, 8'h5A);

        // R9 flag holds until written 0
        repeat (200) @(negedge clk);
        rd(0, c); chk("R9 flag held", c & 1, 1);
        wr(0, 8'h50);
        rd(0, c); chk("R9 flag cleared", c & 1, 0);

        // R7 R8 framing error in mode 1
        send_frame(8'h11, 1'b0, 1'b0, 1'b0);
        rd(0, c); chk("R7 no flag on bad stop", c & 1, 0);
        chk("R8 sel 0 shows mode bit", (c >> 7) & 1, 0);
        rd(1, d); chk("R7 data unchanged", d, 8'h5A);
        wr(4, 1);
        rd(0, c); chk("R7 R8 error visible", (c >> 7) & 1, 1);
        wr(4, 0);
        send_frame(8'h22, 1'b0, 1'b1, 1'b0);
        wr(4, 1);
        rd(0, c); chk("R7 error sticky", (c >> 7) & 1, 1);
        chk("R7 good frame accepted", c & 1, 1);
        wr(0, 8'h50);
        rd(0, c); chk("R8 error cleared by write 0", (c >> 7) & 1, 0);
        wr(4, 0);
        rd(0, c); chk("R8 mode kept", c, 8'h50);
        wr(0, 8'hD0);
        rd(0, c); chk("R8 mode bit written", (c >> 7) & 1, 1);
        wr(4, 1);
        rd(0, c); chk("R8 alias shows error", (c >> 7) & 1, 0);
        wr(4, 0);

        // R10 mode 0 ignores the line, filter bit either way
        wr(0, 8'h10);
        send_frame(8'h33, 1'b1, 1'b1, 1'b1);
        rd(0, c); chk("R10 no flag", c & 1, 0);
        wr(0, 8'h30);
        send_frame(8'h33, 1'b1, 1'b1, 1'b1);
        rd(0, c); chk("R10 no flag filter on", c & 1, 0);
        rd(1, d); chk("R10 data unchanged", d, 8'h22);

        // R12 receive disabled
        wr(0, 8'hC0);
        send_frame(8'h44, 1'b1, 1'b1, 1'b1);
        rd(0, c); chk("R12 no flag", c & 1, 0);
        rd(1, d); chk("R12 data unchanged", d, 8'h22);

        // R2 slower tick: one tick every 3 clocks
        wr(0, 8'hD0);
        div = 3;
        send_frame(8'h96, 1'b1, 1'b1, 1'b1);
        rd(0, c); chk("R2 slow tick flag", c & 1, 1);
        chk("R2 slow tick ninth", (c >> 2) & 1, 1);
        rd(1, d); chk("R2 slow tick data", d, 8'h96);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule